// File: doc/BRIEF.md
# Period-Match Timer with Start and Read Synchronization

This block is an up-counter that advances on edges of an external timer clock. It returns to zero on the counting edge that follows a match with a programmable period value. The external clock is first brought into the system clock domain. An edge detector then turns it into single-cycle count strobes, and the counter updates on those strobes. Software reaches the block through a small register port that holds four registers:

- a run bit,
- a configuration byte,
- the period,
- the counter.

The configuration byte has three options. The first picks which edge of the timer clock counts. The second passes the run bit through a two-stage pipeline that advances on counting edges, so start and stop happen only on timer-clock boundaries. The third re-times the count strobe through one extra system-clock register. The configuration byte also holds a five-bit mode field. That field is stored and read back, but only free-running period operation is built. The timer clock must toggle more slowly than half the system clock rate.

Top module: `ptmr_top`

## Requirements
- R1: After reset, all four registers read 0: run bit, configuration, period and counter. The synchronizer pipelines are empty.
- R2: When configuration bit 6 (edge select) is 0, the counter adds one on each rising edge of `tclk_in` while running. Falling edges have no effect.
- R3: When the counter equals the period on a counting edge, that edge loads 0 into the counter and does not increment it.
- R4: Clearing the run bit (address 0, bit 0) stops counting. The counter keeps its value until counting resumes.
- R5: A write to configuration bit 6 is ignored while the run bit is 1. While the run bit is 0, the write is stored.
- R6: A write to the counter (address 3) while the run bit is 0 loads the written value. While the run bit is 1, the write is ignored.
- R7: When configuration bit 6 is 1, the counter adds one on each falling edge of `tclk_in`. Rising edges have no effect.
- R8: When configuration bit 5 (start sync) is 1, the first two counting edges after the run bit is set do not count, and the third does. After the run bit is cleared, two more counting edges still count.
- R9: When configuration bit 7 (strobe re-time) is 0, a counting transition of `tclk_in` shows at `rdata` at the 4th rising `clk` edge after it. When bit 7 is 1, it shows at the 5th.
- R10: The register map is: address 0 holds the run bit (bit 0), address 1 the configuration (bit 7 re-time, bit 6 edge, bit 5 start sync, bits 4:0 mode), address 2 the period, and address 3 the counter. `rdata` shows the register at `addr`, one `clk` edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oscillator divided by four) |
| rst | input | 1 | Synchronous active-high reset |
| tclk_in | input | 1 | External timer clock, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
A wrong edge detector or a wrong edge select shows as a counter that moves on the wrong half of a timer-clock cycle. It is visible one read after that half-cycle. A start pipeline of the wrong depth shows as a counter value off by one or two, visible within three timer-clock cycles of setting or clearing the run bit. A broken period compare shows as a counter that passes the period instead of returning to zero. A missing or doubled re-time stage moves the `rdata` update by one system clock. The bench samples `rdata` on exact cycles to catch that shift.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef struct packed {
    logic       psync;
    logic       pol;
    logic       csync;
    logic [4:0] mode;
  } cfg_t;

  localparam logic [1:0] A_RUN = 2'd0;
  localparam logic [1:0] A_CFG = 2'd1;
  localparam logic [1:0] A_PER = 2'd2;
  localparam logic [1:0] A_CNT = 2'd3;
endpackage

// File: rtl/ptmr_edge.sv
// Brings the timer clock into the system domain and turns the chosen edge
// into a single-cycle strobe, optionally re-timed by one register.
module ptmr_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tclk_in,
  input  logic pol,
  input  logic psync,
  output logic tick
);
  logic [SYNC_N-1:0] sq;
  logic              last;
  logic              raw;
  logic              tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq     <= '0;
      last   <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      sq     <= {sq[SYNC_N-2:0], tclk_in};
      last   <= sq[SYNC_N-1];
      tick_q <= raw;
    end
  end

  always_comb begin
    if (pol) raw = last & ~sq[SYNC_N-1];
    else     raw = ~last & sq[SYNC_N-1];
  end

  assign tick = psync ? tick_q : raw;

  // A re-timed strobe must trace back to a detected edge one cycle earlier
  AST_RETIMED_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    (psync && tick_q) |-> $past(sq[SYNC_N-1]) != $past(last)); // R9
endmodule

// File: rtl/ptmr_ensync.sv
// Run-bit path: direct, or through a pipeline that advances on count strobes.
module ptmr_ensync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic csync,
  input  logic en,
  output logic run
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst || !csync) pipe <= '0;
    else if (tick)     pipe <= {pipe[STAGES-2:0], en};
  end

  assign run = csync ? pipe[STAGES-1] : en;

  AST_CSYNC_STEADY: assert property (@(posedge clk) disable iff (rst)
    (csync && !tick) |=> (!csync || $stable(run))); // R8
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] per,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (tick && run)  cnt <= (cnt == per) ? '0 : cnt + 1'b1;
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !load && cnt == per) |=> cnt == '0); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !load && cnt != per) |=> cnt == W'($past(cnt) + 1'b1)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!(tick && run) && !load) |=> $stable(cnt)); // R4
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int SYNC_N   = 2,
  parameter int START_N  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tclk_in,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata
);
  localparam int DW = CNT_W;

  logic           en;
  cfg_t           cfg;
  logic [DW-1:0]  per;
  logic [DW-1:0]  cnt;
  logic           tick;
  logic           run;
  logic           load;

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      cfg <= '0;
      per <= '0;
    end else if (wr_en) begin
      case (addr)
        A_RUN: en <= wdata[0];
        A_CFG: begin
          cfg.psync <= wdata[7];
          cfg.csync <= wdata[5];
          cfg.mode  <= wdata[4:0];
          if (!en) cfg.pol <= wdata[6];
        end
        A_PER: per <= wdata;
        default: ;
      endcase
    end
  end

  assign load = wr_en && (addr == A_CNT) && !en;

  ptmr_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk(clk), .rst(rst), .tclk_in(tclk_in),
    .pol(cfg.pol), .psync(cfg.psync), .tick(tick)
  );

  ptmr_ensync #(.STAGES(START_N)) u_ensync (
    .clk(clk), .rst(rst), .tick(tick),
    .csync(cfg.csync), .en(en), .run(run)
  );

  ptmr_count #(.W(DW)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .run(run),
    .load(load), .load_val(wdata), .per(per), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        A_RUN:   rdata <= {{(DW-1){1'b0}}, en};
        A_CFG:   rdata <= DW'(cfg);
        A_PER:   rdata <= per;
        default: rdata <= cnt;
      endcase
    end
  end

  AST_POL_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CFG && en) |=> $stable(cfg.pol)); // R5
  AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CNT && en && !(tick && run)) |=> $stable(cnt)); // R6
endmodule

// File: tb/ptmr_top_test.sv
module ptmr_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tclk_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  ptmr_top uut (
    .clk(clk), .rst(rst), .tclk_in(tclk_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic expect_rd(logic [1:0] a, int exp, string tag);
    @(negedge clk);
    addr = a;
    tag_q.push_back(tag);
    exp_q.push_back(exp);
    wait (exp_q.size() == 0);
  endtask

  // monitor side: rdata is valid one clock after addr is set
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      @(negedge clk);
      chk(tag_q.pop_front(), int'(rdata), exp_q.pop_front());
    end
  end

  task automatic hi();
    @(negedge clk); tclk_in = 1'b1;
    repeat (8) @(negedge clk);
  endtask
  task automatic lo();
    @(negedge clk); tclk_in = 1'b0;
    repeat (8) @(negedge clk);
  endtask
  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin hi(); lo(); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expect_rd(2'd0, 0, "R1 run");
    expect_rd(2'd1, 0, "R1 cfg");
    expect_rd(2'd2, 0, "R1 per");
    expect_rd(2'd3, 0, "R1 cnt");
    // R10 map and mode readback
    wr(2'd1, 8'h15);
    expect_rd(2'd1, 8'h15, "R10 cfg mode");
    wr(2'd1, 8'h00);
    wr(2'd2, 8'd5);
    expect_rd(2'd2, 5, "R10 per");
    wr(2'd0, 8'd1);
    expect_rd(2'd0, 1, "R10 run");
    // R2 rising edges
    cyc(3);
    expect_rd(2'd3, 3, "R2 three rises");
    hi();
    expect_rd(2'd3, 4, "R2 rise counts");
    lo();
    expect_rd(2'd3, 4, "R2 fall ignored");
    // R3 wrap after period match
    hi();
    expect_rd(2'd3, 5, "R3 at period");
    lo(); hi();
    expect_rd(2'd3, 0, "R3 cleared");
    lo();
    cyc(1);
    // R4 hold on stop
    wr(2'd0, 8'd0);
    cyc(3);
    expect_rd(2'd3, 1, "R4 held");
    // R5 polarity lock, R6 load rules
    wr(2'd0, 8'd1);
    wr(2'd1, 8'h40);
    expect_rd(2'd1, 0, "R5 pol write ignored");
    wr(2'd3, 8'd9);
    expect_rd(2'd3, 1, "R6 write while running ignored");
    wr(2'd0, 8'd0);
    wr(2'd1, 8'h40);
    expect_rd(2'd1, 8'h40, "R5 pol stored when stopped");
    wr(2'd3, 8'd0);
    expect_rd(2'd3, 0, "R6 load when stopped");
    // R7 falling edges
    wr(2'd0, 8'd1);
    hi();
    expect_rd(2'd3, 0, "R7 rise ignored");
    lo();
    expect_rd(2'd3, 1, "R7 fall counts");
    cyc(2);
    expect_rd(2'd3, 3, "R7 two more falls");
    wr(2'd0, 8'd0);
    // R8 synchronized start and stop
    wr(2'd1, 8'h20);
    wr(2'd3, 8'd0);
    wr(2'd0, 8'd1);
    cyc(2);
    expect_rd(2'd3, 0, "R8 first two edges skipped");
    cyc(1);
    expect_rd(2'd3, 1, "R8 third edge counts");
    wr(2'd0, 8'd0);
    cyc(2);
    expect_rd(2'd3, 3, "R8 two edges drain after stop");
    cyc(2);
    expect_rd(2'd3, 3, "R8 stopped after drain");
    // R9 read latency without and with re-time
    wr(2'd1, 8'h00);
    wr(2'd3, 8'd0);
    wr(2'd0, 8'd1);
    @(negedge clk); addr = 2'd3;
    repeat (3) @(negedge clk);
    @(negedge clk); tclk_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 direct edge+3", int'(rdata), 0);
    @(negedge clk);
    chk("R9 direct edge+4", int'(rdata), 1);
    repeat (8) @(negedge clk);
    lo();
    wr(2'd1, 8'h80);
    @(negedge clk); addr = 2'd3;
    repeat (3) @(negedge clk);
    @(negedge clk); tclk_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 retimed edge+4", int'(rdata), 1);
    @(negedge clk);
    chk("R9 retimed edge+5", int'(rdata), 2);
    repeat (8) @(negedge clk);
    lo();
    finish_run();
  end
endmodule